// File: doc/BRIEF.md
# Age-Merged Class Queue Scheduler

This block picks the next frame to send on one output port. The port has a number of priority classes, four by default. Each class has a unicast queue and a multicast queue. The queue storage lives elsewhere. The scheduler only sees, for each queue, a non-empty flag and the timestamp of the entry at its head.

Inside a class, the two queues act as one logical queue. Whichever head entry is older goes first. Age is judged by modular subtraction of timestamps, so a counter rollover does not flip the order. Across classes the rule is strict priority: the highest class with any pending frame always wins.

Each decision is registered and presented as a one-hot grant, together with the class number and a unicast/multicast tag. The grant stays frozen until the consumer returns a `done` pulse. After that the grant clears, and the next decision is taken from the queue state that follows.

Top module: `class_age_sched`

## Requirements
- R1: While reset is asserted and in the cycle after reset is released, `grant` is all zeros and `grantValid` is low.
- R2: At most one bit of `grant` is set. `grantValid` is high exactly when one bit is set. The set bit index equals 2*`grantClass` + `grantIsMc` (bit 0 is class 0 unicast, bit 1 is class 0 multicast, and so on).
- R3: Strict priority between classes: a higher class index always wins over a lower one. Class NUM_CLASSES-1 is the highest, whatever the timestamps are.
- R4: Within a class, when both queues are non-empty, the multicast queue wins only if (ucTs - mcTs) mod 2^TS_W lies in 1 .. 2^(TS_W-1)-1, meaning its head is older. This holds across counter wrap-around.
- R5: Within a class, equal head timestamps give the grant to unicast. A modular difference of exactly 2^(TS_W-1) also gives it to unicast.
- R6: If only one queue of the chosen class is non-empty, that queue is granted regardless of the timestamps.
- R7: When every queue is empty, no grant is raised.
- R8: When idle with a request present, the grant appears on the clock edge after the request is seen. It then stays stable, even if the inputs change, until `done` is sampled high.
- R9: When `done` is sampled high with a grant present, the grant clears on that edge. A new grant may appear one edge later at the earliest.
- R10: A `done` pulse while no grant is present has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ucValid | input | NUM_CLASSES | Unicast queue non-empty flag, one bit per class |
| mcValid | input | NUM_CLASSES | Multicast queue non-empty flag, one bit per class |
| ucHeadTs | input | NUM_CLASSES*TS_W | Unicast head timestamps, class c at bits [c*TS_W +: TS_W] |
| mcHeadTs | input | NUM_CLASSES*TS_W | Multicast head timestamps, same layout |
| done | input | 1 | Consumer has accepted the current grant |
| grant | output | 2*NUM_CLASSES | One-hot dequeue grant, index 2*class+isMc |
| grantValid | output | 1 | A grant is outstanding |
| grantClass | output | CLS_W | Class of the granted queue |
| grantIsMc | output | 1 | 1 when the multicast queue is granted |

## Verification
The checker watches several rules on every cycle:
- the grant is one-hot or empty, and its index agrees with the class and tag outputs;
- the grant holds until `done`;
- the grant clears after `done`;
- the grant never rises while all queues are empty.

The choice of winner is left to the bench. That covers strict class priority, age comparison across rollover, the tie and half-range cases, and single-queue classes. The vector table and the directed cases check the exact queue granted, against expected values worked out by hand.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } schedStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } schedState_t;
endpackage

// File: rtl/cas_datapath.sv
module cas_datapath
  import cas_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int TS_W = 8,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int GNT_W = 2 * NUM_CLASSES
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CLASSES-1:0]      ucValid,
  input  logic [NUM_CLASSES-1:0]      mcValid,
  input  logic [NUM_CLASSES*TS_W-1:0] ucHeadTs,
  input  logic [NUM_CLASSES*TS_W-1:0] mcHeadTs,
  input  schedStrobe_t                strobe,
  output logic                        anyReq,
  output logic [GNT_W-1:0]            grant,
  output logic                        grantValid,
  output logic [CLS_W-1:0]            grantClass,
  output logic                        grantIsMc
);
  logic [NUM_CLASSES-1:0] clsReq;
  logic [NUM_CLASSES-1:0] mcPick;

  // Per-class merge: the older head wins, and a tie goes to unicast.
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_merge
    logic [TS_W-1:0] ucTs;
    logic [TS_W-1:0] mcTs;
    logic [TS_W-1:0] ageDiff;
    logic            mcOlder;
    assign ucTs    = ucHeadTs[c*TS_W +: TS_W];
    assign mcTs    = mcHeadTs[c*TS_W +: TS_W];
    assign ageDiff = ucTs - mcTs;
    assign mcOlder = (ageDiff != '0) && !ageDiff[TS_W-1];
    assign clsReq[c] = ucValid[c] | mcValid[c];
    assign mcPick[c] = mcValid[c] & (~ucValid[c] | mcOlder);
  end

  // Strict priority: the highest requesting class index wins.
  logic [CLS_W-1:0] pickCls;
  logic             pickMc;
  always_comb begin
    pickCls = '0;
    pickMc  = 1'b0;
    for (int i = 0; i < NUM_CLASSES; i++) begin
      if (clsReq[i]) begin
        pickCls = CLS_W'(i);
        pickMc  = mcPick[i];
      end
    end
  end

  assign anyReq = |clsReq;

  logic [GNT_W-1:0] nextGrant;
  always_comb begin
    nextGrant = '0;
    nextGrant[{pickCls, pickMc}] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      grant      <= '0;
      grantValid <= 1'b0;
      grantClass <= '0;
      grantIsMc  <= 1'b0;
    end else if (strobe.load) begin
      grant      <= nextGrant;
      grantValid <= 1'b1;
      grantClass <= pickCls;
      grantIsMc  <= pickMc;
    end
  end
endmodule

// File: rtl/cas_control.sv
module cas_control
  import cas_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyReq,
  input  logic         done,
  output schedStrobe_t strobe
);
  schedState_t state;
  schedState_t stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (anyReq) begin
        strobe.load = 1'b1;
        stateNext   = ST_BUSY;
      end
      ST_BUSY: if (done) begin
        strobe.clear = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/class_age_sched.sv
module class_age_sched
  import cas_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int TS_W = 8,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CLASSES-1:0]      ucValid,
  input  logic [NUM_CLASSES-1:0]      mcValid,
  input  logic [NUM_CLASSES*TS_W-1:0] ucHeadTs,
  input  logic [NUM_CLASSES*TS_W-1:0] mcHeadTs,
  input  logic                        done,
  output logic [2*NUM_CLASSES-1:0]    grant,
  output logic                        grantValid,
  output logic [CLS_W-1:0]            grantClass,
  output logic                        grantIsMc
);
  schedStrobe_t strobe;
  logic         anyReq;

  cas_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyReq (anyReq),
    .done   (done),
    .strobe (strobe)
  );

  cas_datapath #(.NUM_CLASSES(NUM_CLASSES), .TS_W(TS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ucValid    (ucValid),
    .mcValid    (mcValid),
    .ucHeadTs   (ucHeadTs),
    .mcHeadTs   (mcHeadTs),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .grant      (grant),
    .grantValid (grantValid),
    .grantClass (grantClass),
    .grantIsMc  (grantIsMc)
  );
endmodule

// File: rtl/class_age_sched_chk.sv
module class_age_sched_chk #(
  parameter int NUM_CLASSES = 4,
  parameter int CLS_W = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CLASSES-1:0]   ucValid,
  input logic [NUM_CLASSES-1:0]   mcValid,
  input logic                     done,
  input logic [2*NUM_CLASSES-1:0] grant,
  input logic                     grantValid,
  input logic [CLS_W-1:0]         grantClass,
  input logic                     grantIsMc
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R2
  grant_valid_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == ($countones(grant) == 1));

  // R2
  grant_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grant[{grantClass, grantIsMc}]);

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !done) |=> (grantValid && $stable(grant)));

  // R9
  grant_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && done) |=> !grantValid);

  // R7
  no_phantom_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && ucValid == '0 && mcValid == '0) |=> !grantValid);
endmodule

bind class_age_sched class_age_sched_chk #(
  .NUM_CLASSES(NUM_CLASSES),
  .CLS_W(CLS_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ucValid    (ucValid),
  .mcValid    (mcValid),
  .done       (done),
  .grant      (grant),
  .grantValid (grantValid),
  .grantClass (grantClass),
  .grantIsMc  (grantIsMc)
);

// File: tb/sim_class_age_sched.sv
module sim_class_age_sched;
  localparam int NC = 4;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] ucValid = '0;
  logic [NC-1:0] mcValid = '0;
  logic [NC*TW-1:0] ucHeadTs = '0;
  logic [NC*TW-1:0] mcHeadTs = '0;
  logic          done = 1'b0;
  logic [2*NC-1:0] grant;
  logic          grantValid;
  logic [1:0]    grantClass;
  logic          grantIsMc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  class_age_sched #(.NUM_CLASSES(NC), .TS_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .ucValid(ucValid), .mcValid(mcValid),
    .ucHeadTs(ucHeadTs), .mcHeadTs(mcHeadTs), .done(done),
    .grant(grant), .grantValid(grantValid), .grantClass(grantClass),
    .grantIsMc(grantIsMc)
  );

  // Fields: ucValid[79:76] mcValid[75:72] ucHeadTs[71:40] mcHeadTs[39:8] expected grant[7:0]
  localparam int NV = 8;
  localparam logic [79:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 32'h0000_0000, 32'h0000_0000, 8'h01}, // R6 lone unicast
    {4'b0010, 4'b0010, 32'h0000_0A00, 32'h0000_0500, 8'h08}, // R4 mc older
    {4'b0100, 4'b0100, 32'h0007_0000, 32'h0007_0000, 8'h10}, // R5 tie
    {4'b1000, 4'b1000, 32'h0200_0000, 32'hFA00_0000, 8'h80}, // R4 wrap
    {4'b0001, 4'b1000, 32'h0000_0000, 32'hC800_0000, 8'h80}, // R3 class 3 over older class 0
    {4'b0110, 4'b0110, 32'h0032_0000, 32'h003C_0000, 8'h10}, // R3 R4 uc older in class 2
    {4'b0000, 4'b0001, 32'h0000_00FF, 32'h0000_0000, 8'h02}, // R6 lone multicast
    {4'b0010, 4'b0010, 32'h0000_8000, 32'h0000_0000, 8'h04}  // R5 half range
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset grant", 32'(grant), 0);
    chk("R1 reset valid", 32'(grantValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(grantValid), 0);

    // R7 all queues empty
    repeat (3) @(negedge clk);
    chk("R7 empty no grant", 32'(grant), 0);

    // R10 done while idle has no effect
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R10 idle done", 32'(grantValid), 0);

    for (int v = 0; v < NV; v++) begin
      ucValid  = VEC[v][79:76];
      mcValid  = VEC[v][75:72];
      ucHeadTs = VEC[v][71:40];
      mcHeadTs = VEC[v][39:8];
      @(negedge clk);
      chk("R3 R4 R5 R6 grant", 32'(grant), 32'(VEC[v][7:0]));
      chk("R2 class tag", 32'({grantClass, grantIsMc}), 32'($clog2(VEC[v][7:0])));
      chk("R8 valid", 32'(grantValid), 1);
      done = 1'b1;
      ucValid = '0;
      mcValid = '0;
      @(negedge clk);
      done = 1'b0;
      chk("R9 cleared", 32'(grantValid), 0);
    end

    // R8 grant holds while inputs change without done
    ucValid = 4'b0001;
    mcValid = '0;
    @(negedge clk);
    chk("R8 first grant", 32'(grant), 32'h01);
    ucValid = 4'b1000;
    mcValid = 4'b1000;
    repeat (3) @(negedge clk);
    chk("R8 held", 32'(grant), 32'h01);

    // R9 one-cycle gap, then a new decision from current inputs
    ucHeadTs = 32'h1000_0000;
    mcHeadTs = 32'h0F00_0000;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R9 gap", 32'(grant), 0);
    @(negedge clk);
    chk("R9 new grant", 32'(grant), 32'h80);
    done = 1'b1;
    ucValid = '0;
    mcValid = '0;
    @(negedge clk);
    done = 1'b0;

    // R7 after draining, stays empty
    repeat (2) @(negedge clk);
    chk("R7 drained", 32'(grantValid), 0);

    // R1 reset mid-grant clears
    mcValid = 4'b0100;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", 32'(grant), 0);

    finishRun();
  end
endmodule